// File: doc/BRIEF.md
# Folded Single-Port Word Memory

This block is a synchronous single-port memory of 2048 words of 16 bits. Instead of one storage entry per word, it keeps 256 wide rows of 128 bits each, so that eight words share every row. The word address is split in two. The high part picks a row through a predecoded wordline decoder. The low part picks, for every output bit, one column out of a group of eight.

Each clock cycle is exactly one access. When write enable is high, the addressed word is merged into its row. When it is low, the addressed word is read into an output register. Software-visible behaviour is that of a plain word memory. The folded organisation is what the block models at register-transfer level.

Top module: `sram_fold`

## Requirements
- R1: The array holds 256 rows of 128 columns. Address bits [10:3] select the row and bits [2:0] select the column group, so addresses that differ in either part reach distinct words.
- R2: Output bit i of a word comes from an 8:1 selector over columns i*8 to i*8+7 of the selected row, and the column group value picks the entry.
- R3: Exactly one wordline is active in every cycle, and it is the line whose index equals the row address.
- R4: A write changes only the 16 columns of the addressed word. The other seven words of the same row, and all other rows, keep their contents.
- R5: A read presents its data on the output in the clock cycle after the address is applied. Back-to-back reads return one word per cycle.
- R6: In a write cycle no read takes place, and the read data output keeps its previous value.
- R7: While rst_n is low, the read data output is zero. Array contents are not reset.
- R8: A read of an address in the cycle right after a write to it returns the newly written data.
- R9: The row address is cut into two 4-bit fields. Each field is decoded into 16 one-hot lines, and a wordline is the AND of one line from each field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the read register |
| addr | input | 11 | Word address: row in [10:3], column group in [2:0] |
| we | input | 1 | 1 = write this cycle, 0 = read this cycle |
| wdata | input | 16 | Data to write |
| rdata | output | 16 | Registered read data |

## Verification
A decoder fault that raises no wordline, or raises the wrong one, sends a write to the wrong row or drops it. The port then shows a stale or foreign word on the next read of either affected address, however many cycles later that read happens. A mis-wired column selector or write mask scrambles bit positions or damages the neighbouring words in a row. That shows up on the first read of the damaged word, one cycle after its address is applied. The bench compares every read against a flat word-indexed model over a full fill, directed row-neighbour cases and a long random mix, so each such corruption is caught at the read that exposes it.

// File: rtl/sram_fold_pkg.sv
package sram_fold_pkg;

  // First column of the group that serves output bit bit_i
  function automatic int col_base(input int bit_i, input int fold);
    return bit_i * fold;
  endfunction

  // Which predecoder line of field g a given row index uses
  function automatic int pre_line(input int row, input int g, input int pre_w);
    return (row >> (g * pre_w)) % (1 << pre_w);
  endfunction

  // Word (output bit) that owns a physical column
  function automatic int owner_bit(input int col, input int fold);
    return col / fold;
  endfunction

endpackage

// File: rtl/sram_fold_rowdec.sv
module sram_fold_rowdec
  import sram_fold_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int PRE_W = 4
) (
  input  logic [ROW_W-1:0]              row_addr,
  output logic [(ROW_W/PRE_W)*(1<<PRE_W)-1:0] pre_lines,
  output logic [(1<<ROW_W)-1:0]         wordline
);
  localparam int NGRP  = ROW_W / PRE_W;
  localparam int LINES = 1 << PRE_W;
  localparam int ROWS  = 1 << ROW_W;

  // Predecode each address field into one-hot lines
  for (genvar g = 0; g < NGRP; g++) begin : g_pre
    assign pre_lines[g*LINES +: LINES] = LINES'(1) << row_addr[g*PRE_W +: PRE_W];
  end

  // Each wordline ANDs one line from every field
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [NGRP-1:0] terms;
    for (genvar g = 0; g < NGRP; g++) begin : g_term
      assign terms[g] = pre_lines[g*LINES + pre_line(r, g, PRE_W)];
    end
    assign wordline[r] = &terms;
  end
endmodule

// File: rtl/sram_fold_colsel.sv
module sram_fold_colsel
  import sram_fold_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COL_W  = 3
) (
  input  logic [DATA_W*(1<<COL_W)-1:0] row_bits,
  input  logic [COL_W-1:0]             col_sel,
  output logic [DATA_W-1:0]            word
);
  localparam int FOLD = 1 << COL_W;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam int BASE = col_base(i, FOLD);
    logic [FOLD-1:0] cand;
    assign cand    = row_bits[BASE +: FOLD];
    assign word[i] = cand[col_sel];
  end
endmodule

// File: rtl/sram_fold.sv
module sram_fold
  import sram_fold_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int COL_W  = 3,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int FOLD  = 1 << COL_W;
  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = DATA_W * FOLD;
  localparam int NPRE  = (ROW_W / PRE_W) * (1 << PRE_W);

  logic [ROW_W-1:0] row_a;
  logic [COL_W-1:0] col_a;
  assign row_a = addr[ADDR_W-1 -: ROW_W];
  assign col_a = addr[COL_W-1:0];

  // Named internal events for the checker
  logic [ROWS-1:0] wordline;
  logic [NPRE-1:0] pre_lines;
  logic [COLS-1:0] row_rd;
  logic [COLS-1:0] wr_mask;
  logic [COLS-1:0] wr_spread;
  logic [COLS-1:0] row_new;
  logic [DATA_W-1:0] word_rd;

  logic [COLS-1:0] mem [ROWS];

  sram_fold_rowdec #(.ROW_W(ROW_W), .PRE_W(PRE_W)) i_rowdec (
    .row_addr (row_a),
    .pre_lines(pre_lines),
    .wordline (wordline)
  );

  // Wordline-selected row onto the shared bitlines
  always_comb begin
    row_rd = '0;
    for (int r = 0; r < ROWS; r++) begin
      row_rd = row_rd | ({COLS{wordline[r]}} & mem[r]);
    end
  end

  // Column-group write mask and data spread across the row
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign wr_mask[c]   = (col_a == COL_W'(c % FOLD));
    assign wr_spread[c] = wdata[owner_bit(c, FOLD)];
  end
  assign row_new = (row_rd & ~wr_mask) | (wr_spread & wr_mask);

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (we && wordline[r]) mem[r] <= row_new;
    end
  end

  sram_fold_colsel #(.DATA_W(DATA_W), .COL_W(COL_W)) i_colsel (
    .row_bits(row_rd),
    .col_sel (col_a),
    .word    (word_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)   rdata <= '0;
    else if (!we) rdata <= word_rd;
  end
endmodule

// File: rtl/sram_fold_chk.sv
module sram_fold_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int COL_W  = 3,
  parameter int PRE_W  = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [ADDR_W-1:0]                addr,
  input logic                             we,
  input logic [DATA_W-1:0]                wdata,
  input logic [DATA_W-1:0]                rdata,
  input logic [(1<<(ADDR_W-COL_W))-1:0]   wordline,
  input logic [((ADDR_W-COL_W)/PRE_W)*(1<<PRE_W)-1:0] pre_lines
);
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int NGRP  = ROW_W / PRE_W;
  localparam int LINES = 1 << PRE_W;

  logic [ROW_W-1:0] row_a;
  assign row_a = addr[ADDR_W-1 -: ROW_W];

  // R3
  wl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wordline) == 1);

  // R3
  wl_row_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wordline[row_a] == 1'b1);

  for (genvar g = 0; g < NGRP; g++) begin : g_pre_chk
    // R9
    pre_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pre_lines[g*LINES +: LINES]) == 1);
  end

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> $stable(rdata));

  // R8
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we ##1 (!we && addr == $past(addr)) |=> rdata == $past(wdata, 2));
endmodule

bind sram_fold sram_fold_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W), .PRE_W(PRE_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .we       (we),
  .wdata    (wdata),
  .rdata    (rdata),
  .wordline (wordline),
  .pre_lines(pre_lines)
);

// File: tb/test_sram_fold.sv
`timescale 1ns/1ps
module test_sram_fold;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  always #2.5 clk = ~clk;

  sram_fold i_sram_fold (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [15:0] ref_mem [2048];
  logic [15:0] last_rd = '0;

  int          due_q [$];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pop expected items when their cycle arrives
  always @(negedge clk) begin
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      int          d;
      logic [15:0] e;
      string       t;
      d = due_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h (cycle %0d)", t, rdata, e, d);
      end
    end
  end

  task automatic push(input logic [15:0] e, input string t);
    due_q.push_back(cyc + 1);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // Write: output must hold last read value (R6)
  task automatic wr(input logic [10:0] a, input logic [15:0] d, input bit chk);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    ref_mem[a] = d;
    if (chk) push(last_rd, "R6 write hold");
  endtask

  task automatic rd(input logic [10:0] a, input string t);
    @(negedge clk);
    addr = a; we = 1'b0;
    push(ref_mem[a], t);
    last_rd = ref_mem[a];
  endtask

  function automatic logic [15:0] fill_pat(input int a);
    return 16'((a * 40503) ^ 16'h5A5A);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R7: reset value
    checks++;
    if (rdata !== 16'h0000) begin
      errors++;
      $display("FAIL R7 reset: rdata=%h expected=0000", rdata);
    end
    we = 1'b1; addr = '0; wdata = fill_pat(0);
    @(negedge clk);
    rst_n = 1'b1;

    // Fill the whole memory (R1)
    for (int a = 0; a < 2048; a++) wr(11'(a), fill_pat(a), 1'b0);

    // R1: boundary and distinct row/column addresses
    rd(11'd0,    "R1 addr 0");
    rd(11'd2047, "R1 addr 2047");
    rd(11'd8,    "R1 row 1 col 0");
    rd(11'h400,  "R1 row 128 col 0");
    rd(11'd7,    "R1 row 0 col 7");

    // R2: all-ones / alternating words in one row
    wr(11'h123, 16'hFFFF, 1'b1);
    wr(11'h124, 16'hAAAA, 1'b1);
    wr(11'h125, 16'h5555, 1'b1);
    rd(11'h123, "R2 bit spread ones");
    rd(11'h124, "R2 bit spread AAAA");
    rd(11'h125, "R2 bit spread 5555");

    // R4: neighbours in the row and the next row stay intact
    for (int c = 0; c < 8; c++) wr(11'(37*8 + c), 16'h0000, 1'b1);
    wr(11'(38*8 + 3), 16'h0000, 1'b1);
    wr(11'(37*8 + 3), 16'hFFFF, 1'b1);
    for (int c = 0; c < 8; c++) rd(11'(37*8 + c), "R4 row neighbour");
    rd(11'(38*8 + 3), "R4 other row");

    // R8: write immediately followed by read of the same address
    wr(11'h7F0, 16'hBEEF, 1'b1);
    rd(11'h7F0, "R8 write then read");
    wr(11'h001, 16'h1234, 1'b1);
    rd(11'h001, "R8 write then read");

    // R5: back-to-back reads of different addresses
    for (int a = 100; a < 116; a++) rd(11'(a * 13), "R5 back-to-back read");

    // Random mix against flat reference (R1 R4 R5 R6)
    for (int n = 0; n < 4000; n++) begin
      logic [10:0] ra;
      ra = 11'($urandom_range(0, 2047));
      if ($urandom_range(0, 1) == 0) wr(ra, 16'($urandom), 1'b1);
      else rd(ra, "R5 random read");
    end

    @(negedge clk); we = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule